// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block watches a general-purpose I/O port and pulls an open-drain interrupt line low whenever a pin that is configured as an input holds a level different from a stored snapshot. The snapshot is taken when the bus interface reads the input register. A read therefore acknowledges the interrupt. If a changed pin goes back to its snapshot level before anyone reads, the request withdraws by itself, because the interrupt is a level comparison and not a latched event.

Pin levels arrive asynchronously and pass through a synchronizer of `SYNC_STAGES` flops before the comparison. The direction mask is registered once inside the block. Turning an output into an input can raise a request at once if that pin disagrees with the snapshot, and this is intended behaviour. The snapshot byte is presented as an output so that the bus side can return it as the read data.

Top module: `pin_change_irq`

## Requirements
- R1: While `rstN` is low at a clock edge, the snapshot loads all ones (`SNAP_INIT`), the registered direction mask loads all ones (every pin an input), and `intPullLow` is 0 (line released) once reset ends.
- R2: When an input pin changes to a level that differs from its snapshot bit, `intPullLow` becomes 1 after exactly `SYNC_STAGES` rising clock edges, and not earlier.
- R3: A pin whose `dirIsInput` bit is 0 (output) never causes `intPullLow` to be 1, and its level changes leave `snapshot` unchanged.
- R4: If every differing input pin returns to its snapshot level, `intPullLow` returns to 0 after `SYNC_STAGES` edges, with no read.
- R5: On the first clock edge at which `readStrobe` is high after being low, `snapshot` takes the synchronized pin levels, and `intPullLow` is 0 after that edge unless a pin changes in the same cycle.
- R6: A `readStrobe` held high for several cycles loads the snapshot only on its first cycle. A pin that changes while the strobe stays high still raises `intPullLow`.
- R7: Changing a `dirIsInput` bit from 0 to 1 while that pin's level differs from its snapshot bit makes `intPullLow` 1 one edge later.
- R8: The interrupt compares against the snapshot rather than the previous level. After a read, a pin that returns to a level it held before the read raises `intPullLow` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pinLevels | input | PORT_W | Raw pin levels, asynchronous |
| dirIsInput | input | PORT_W | Per-pin direction, 1 = input, 0 = output |
| readStrobe | input | 1 | High while the bus reads the input register |
| intPullLow | output | 1 | 1 = drive the open-drain interrupt line low |
| snapshot | output | PORT_W | Pin levels captured at the last read |

## Verification
The bench uses the defaults: an 8-bit port and a two-stage synchronizer. At this size every pin and a split direction nibble can be exercised with short directed sequences. Two stages make the latency edge easy to probe: the bench checks that the line is still released one edge after a pin change and asserted on the second. With these values the same vectors also reach the held-strobe case and a pin change that lands while the strobe is still high.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

  // Strobes issued by control to the datapath each cycle.
  typedef struct packed {
    logic loadSnap;
  } ctrlStrobe_t;

endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= INIT;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[LAST];

endmodule

// File: rtl/pcirq_ctrl.sv
module pcirq_ctrl
  import pcirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        readStrobe,
  output ctrlStrobe_t strobes
);

  logic readPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) readPrevQ <= 1'b0;
    else       readPrevQ <= readStrobe;
  end

  // One snapshot load per read access, on its leading cycle.
  always_comb begin
    strobes          = '0;
    strobes.loadSnap = readStrobe & ~readPrevQ;
  end

endmodule

// File: rtl/pcirq_datapath.sv
module pcirq_datapath
  import pcirq_pkg::*;
#(
  parameter int unsigned PORT_W         = 8,
  parameter logic [PORT_W-1:0] SNAP_INIT = '1,
  parameter logic [PORT_W-1:0] DIR_INIT  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] syncPins,
  input  logic [PORT_W-1:0] dirIsInput,
  input  ctrlStrobe_t       strobes,
  output logic [PORT_W-1:0] snapQ,
  output logic [PORT_W-1:0] dirQ,
  output logic              intPullLow
);

  logic [PORT_W-1:0] diffBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapQ <= SNAP_INIT;
      dirQ  <= DIR_INIT;
    end else begin
      dirQ <= dirIsInput;
      if (strobes.loadSnap) snapQ <= syncPins;
    end
  end

  // Compare straight off flops: snapshot and sync stage update on the
  // same edge, so a read never leaves a stale mismatch behind.
  always_comb begin
    diffBits   = (syncPins ^ snapQ) & dirQ;
    intPullLow = |diffBits;
  end

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcirq_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] SNAP_INIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinLevels,
  input  logic [PORT_W-1:0] dirIsInput,
  input  logic              readStrobe,
  output logic              intPullLow,
  output logic [PORT_W-1:0] snapshot
);

  localparam logic [PORT_W-1:0] DIR_INIT = '1;

  logic [PORT_W-1:0] syncPins;
  logic [PORT_W-1:0] dirQ;
  ctrlStrobe_t       ctrlStrobes;

  pcirq_sync #(
    .WIDTH (PORT_W),
    .STAGES(SYNC_STAGES),
    .INIT  (SNAP_INIT)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinLevels),
    .dout(syncPins)
  );

  pcirq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .readStrobe(readStrobe),
    .strobes   (ctrlStrobes)
  );

  pcirq_datapath #(
    .PORT_W   (PORT_W),
    .SNAP_INIT(SNAP_INIT),
    .DIR_INIT (DIR_INIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .syncPins  (syncPins),
    .dirIsInput(dirIsInput),
    .strobes   (ctrlStrobes),
    .snapQ     (snapshot),
    .dirQ      (dirQ),
    .intPullLow(intPullLow)
  );

endmodule

// File: rtl/pin_change_irq_checker.sv
module pin_change_irq_checker #(
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] SNAP_INIT = '1
) (
  input logic              clk,
  input logic              rstN,
  input logic              readStrobe,
  input logic              loadSnap,
  input logic [PORT_W-1:0] syncPins,
  input logic [PORT_W-1:0] dirMask,
  input logic [PORT_W-1:0] snapshot,
  input logic              intPullLow
);

  // R1: state leaving reset is the documented default
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rstN) |-> (snapshot == SNAP_INIT && dirMask == '1 && !intPullLow));

  // R3: with no input pins the line stays released
  a_r3_outputs_masked: assert property (@(posedge clk) disable iff (!rstN)
    (dirMask == '0) |-> !intPullLow);

  // R2: agreement between synchronized pins and snapshot means no request
  a_r2_match_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (syncPins == snapshot) |-> !intPullLow);

  // R5: a leading read cycle captures the synchronized levels
  a_r5_read_loads: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !$past(readStrobe)) |=> (snapshot == $past(syncPins)));

  // R6: a strobe held on does not reload
  a_r6_held_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && $past(readStrobe)) |=> $stable(snapshot));

  // R5: only the control strobe moves the snapshot
  a_r5_snap_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !loadSnap |=> $stable(snapshot));

  // R7: a request only rises with a pin or direction change
  a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intPullLow) |-> (!$stable(syncPins) || !$stable(dirMask)));

endmodule

bind pin_change_irq pin_change_irq_checker #(
  .PORT_W   (PORT_W),
  .SNAP_INIT(SNAP_INIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .readStrobe(readStrobe),
  .loadSnap  (ctrlStrobes.loadSnap),
  .syncPins  (syncPins),
  .dirMask   (dirQ),
  .snapshot  (snapshot),
  .intPullLow(intPullLow)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] pinLevels = '1;
  logic [W-1:0] dirIsInput = '1;
  logic         readStrobe = 1'b0;
  logic         intPullLow;
  logic [W-1:0] snapshot;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pin_change_irq #(.PORT_W(W), .SYNC_STAGES(2)) u_pin_change_irq (
    .clk(clk), .rstN(rstN), .pinLevels(pinLevels), .dirIsInput(dirIsInput),
    .readStrobe(readStrobe), .intPullLow(intPullLow), .snapshot(snapshot)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkInt(input string req, input logic exp);
    nChecks++;
    if (intPullLow !== exp) begin
      nFails++;
      $display("FAIL %s intPullLow actual=%0b expected=%0b", req, intPullLow, exp);
    end
  endtask

  task automatic chkSnap(input string req, input logic [W-1:0] exp);
    nChecks++;
    if (snapshot !== exp) begin
      nFails++;
      $display("FAIL %s snapshot actual=%02h expected=%02h", req, snapshot, exp);
    end
  endtask

  task automatic doRead();
    readStrobe = 1'b1;
    edges(1);
    readStrobe = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    pinLevels = 8'h00;
    edges(3);
    pinLevels = '1;
    edges(3);
    rstN = 1'b1;
    edges(1);
    chkInt("R1", 1'b0);
    chkSnap("R1", 8'hFF);
  endtask

  task automatic testAssertReturn();
    pinLevels = 8'hF7;           // bit 3 low
    edges(1);
    chkInt("R2 latency", 1'b0);
    edges(1);
    chkInt("R2", 1'b1);
    pinLevels = 8'hFF;           // back to snapshot level
    edges(1);
    chkInt("R4 latency", 1'b1);
    edges(1);
    chkInt("R4", 1'b0);
    chkSnap("R4", 8'hFF);
  endtask

  task automatic testMaskedAndSwitch();
    dirIsInput = 8'hF0;          // low nibble outputs
    edges(1);
    pinLevels = 8'hF0;
    edges(4);
    chkInt("R3", 1'b0);
    chkSnap("R3", 8'hFF);
    dirIsInput = 8'hFF;          // outputs become inputs, mismatch present
    edges(1);
    chkInt("R7", 1'b1);
    doRead();
    chkSnap("R5", 8'hF0);
    chkInt("R5", 1'b0);
  endtask

  task automatic testHeldRead();
    readStrobe = 1'b1;
    edges(1);
    chkSnap("R6 load", 8'hF0);
    pinLevels = 8'hF1;
    edges(2);
    chkInt("R6", 1'b1);
    chkSnap("R6 no reload", 8'hF0);
    readStrobe = 1'b0;
    edges(1);
    doRead();
    chkSnap("R6 next read", 8'hF1);
    chkInt("R6 cleared", 1'b0);
  endtask

  task automatic testSnapshotReference();
    pinLevels = 8'h0F;
    edges(2);
    chkInt("R8 change", 1'b1);
    doRead();
    chkSnap("R8 capture", 8'h0F);
    chkInt("R8 clear", 1'b0);
    pinLevels = 8'hF1;           // level held before the read
    edges(2);
    chkInt("R8", 1'b1);
    pinLevels = 8'h0F;
    edges(2);
    chkInt("R8 return", 1'b0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testAssertReturn();
    testMaskedAndSwitch();
    testHeldRead();
    testSnapshotReference();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule